// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores received frames into memory by walking a circular list of buffer descriptors. Each descriptor occupies two consecutive 32-bit words. The first word holds the buffer address, with a done flag in bit 0 and a wrap flag in bit 1. The second word is a status word that the block fills in. When the block is enabled, it loads the ring base and fetches the first descriptor. If that descriptor is free, the block waits for a frame. It writes the frame's words one after another into the buffer. It then records the length and the multicast indication in the status word and sets the done flag in the address word. Finally it moves on to the next descriptor, or back to the ring base after a descriptor that is marked wrap.

Software hands a buffer back by clearing its done flag. If the block fetches a descriptor whose done flag is still set, it raises a buffer-not-available cause and stops. Reception resumes only when the enable input is taken low and then high again, which restarts the ring at its first descriptor. A frame that begins while the block is busy or stopped is discarded and raises an overrun cause. The three causes collect in a status register that clears when it is read.

Frame words arrive on a stream that has no backpressure. The block uses a single memory port with one-cycle read latency.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After reset the cause status is zero and no memory access is made. While rx_enable is low the block is idle. When it is seen high, the block loads ring_base with bits 2:0 forced to zero and fetches the descriptor at that address. A frame may start from the fourth cycle after the enable.
- R2: A descriptor is claimed when bit 0 of its address word is 0. The frame words are written to consecutive word addresses, starting at the address word with bits 1:0 cleared.
- R3: After the last frame word, the status word at descriptor address + 4 is written. Bits 10:0 hold frm_len, bit 31 holds frm_mcast, and all other bits are zero.
- R4: After the status word, the address word is rewritten with bit 0 set and all other bits unchanged.
- R5: The next descriptor is at the current address + 8. If bit 1 of the current address word is set, the next descriptor is the ring base instead.
- R6: Cause bit 0 (receive complete) is set once the done flag of a frame's descriptor has been written.
- R7: If a fetched descriptor has bit 0 set, cause bit 1 (buffer not available) is set and the block stops making memory accesses. Releasing descriptors does not restart it. Only rx_enable going low and then high restarts it, at the first descriptor.
- R8: A frame whose first word arrives while rx_enable is high but the block is not waiting for a frame sets cause bit 2 (overrun). This covers a stopped block and a block that is still fetching or writing back. The whole frame is discarded with no memory write, and the next frame uses the same free descriptor.
- R9: A pulse on stat_rd clears irq_status in the next cycle, except for causes raised in that same cycle. irq is high whenever any cause bit is set.
- R10: Frames arriving while rx_enable is low cause no memory access and raise no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receive enable; a low-to-high change restarts the ring |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| frm_valid | input | 1 | A frame word is present |
| frm_data | input | DATA_W | Frame word |
| frm_last | input | 1 | This word is the last of its frame |
| frm_len | input | LEN_W | Frame length in bytes including FCS, valid with frm_last |
| frm_mcast | input | 1 | Frame is multicast, valid with frm_last |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after a read request |
| stat_rd | input | 1 | Read strobe for the cause status |
| irq_status | output | 3 | Causes: bit 0 complete, bit 1 no buffer, bit 2 overrun |
| irq | output | 1 | Any cause pending |

## Verification
Several properties are checked on every cycle by assertions:
- the descriptor pointer stays 8-byte aligned, steps by 8, and returns to the base after a wrap descriptor;
- every write to the current descriptor's address word carries the done flag;
- no memory access is made while disabled or stopped;
- cause bits stay set until a read and clear after it.

Some behaviour can only be shown by the bench's scenarios, comparing memory contents against its own ring model:
- the buffer contents, the packed length and multicast fields, and that wrap and address bits are preserved;
- that a stop persists until an enable toggle, and that the ring then restarts at index zero;
- that frames dropped for overrun leave their descriptor untouched.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_FETCH,
        S_WAIT,
        S_READY,
        S_DATA,
        S_WSTAT,
        S_WADDR,
        S_STALL
    } rxr_state_e;

    localparam int CAUSE_W    = 3;
    localparam int CAUSE_RCOM = 0;
    localparam int CAUSE_BNA  = 1;
    localparam int CAUSE_OVR  = 2;

    localparam int DONE_BIT   = 0;
    localparam int WRAP_BIT   = 1;

    localparam int DESC_BYTES = 8;
    localparam int STAT_OFS   = 4;
    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] cur
);
    import rxr_pkg::*;

    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN = ADDR_W'(DESC_BYTES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] cur;
    } ptr_t;

    ptr_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.base = base_in & ~ALIGN;
            d.cur  = base_in & ~ALIGN;
        end else if (advance) begin
            d.cur = wrap ? q.base : (q.cur + STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur = q.cur;

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cur & ALIGN) == '0);  // R1
    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap && !load) |=> (q.cur == q.base));  // R5
    AST_STEP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wrap && !load) |=> (q.cur == $past(q.cur) + STEP));  // R5

endmodule

// File: rtl/rxr_cause_reg.sv
module rxr_cause_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         rd,
    output logic [W-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] bits;
    } cause_t;

    cause_t q, d;

    always_comb begin
        d = q;
        if (rd) d.bits = set;
        else    d.bits = q.bits | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status = q.bits;
    assign irq    = |q.bits;

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && set == '0) |=> (status == '0));  // R9
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((status & $past(status)) == $past(status)));  // R9

endmodule

// File: rtl/rxr_seq.sv
module rxr_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_enable,
    input  logic                        frm_valid,
    input  logic [DATA_W-1:0]           frm_data,
    input  logic                        frm_last,
    input  logic [LEN_W-1:0]            frm_len,
    input  logic                        frm_mcast,
    input  logic [ADDR_W-1:0]           cur_addr,
    output logic                        ptr_load,
    output logic                        ptr_advance,
    output logic                        ptr_wrap,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic [rxr_pkg::CAUSE_W-1:0] cause_set
);
    import rxr_pkg::*;

    localparam logic [ADDR_W-1:0] WSTEP   = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] SOFS    = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] WALIGN  = ADDR_W'(WORD_BYTES - 1);

    typedef struct packed {
        rxr_state_e        state;
        logic [ADDR_W-1:0] buf_addr;
        logic [DATA_W-1:0] desc_word;
        logic [LEN_W-1:0]  len;
        logic              mcast;
        logic              in_frame;
    } seq_t;

    seq_t q, d;
    logic frame_start;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        stat_word                = '0;
        stat_word[LEN_W-1:0]     = q.len;
        stat_word[DATA_W-1]      = q.mcast;
    end

    always_comb begin
        d           = q;
        ptr_load    = 1'b0;
        ptr_advance = 1'b0;
        ptr_wrap    = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        cause_set   = '0;
        frame_start = frm_valid && !q.in_frame;

        if (frm_valid) d.in_frame = !frm_last;

        if (!rx_enable) begin
            d.state = S_OFF;
        end else begin
            if (frame_start && q.state != S_READY)
                cause_set[CAUSE_OVR] = 1'b1;

            case (q.state)
                S_OFF: begin
                    ptr_load = 1'b1;
                    d.state  = S_FETCH;
                end
                S_FETCH: begin
                    mem_req  = 1'b1;
                    mem_addr = cur_addr;
                    d.state  = S_WAIT;
                end
                S_WAIT: begin
                    if (mem_rdata[DONE_BIT]) begin
                        cause_set[CAUSE_BNA] = 1'b1;
                        d.state = S_STALL;
                    end else begin
                        d.desc_word = mem_rdata;
                        d.buf_addr  = ADDR_W'(mem_rdata) & ~WALIGN;
                        d.state     = S_READY;
                    end
                end
                S_READY, S_DATA: begin
                    if ((q.state == S_READY && frame_start) ||
                        (q.state == S_DATA && frm_valid)) begin
                        mem_req    = 1'b1;
                        mem_we     = 1'b1;
                        mem_addr   = q.buf_addr;
                        mem_wdata  = frm_data;
                        d.buf_addr = q.buf_addr + WSTEP;
                        d.state    = S_DATA;
                        if (frm_last) begin
                            d.len   = frm_len;
                            d.mcast = frm_mcast;
                            d.state = S_WSTAT;
                        end
                    end
                end
                S_WSTAT: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = cur_addr + SOFS;
                    mem_wdata = stat_word;
                    d.state   = S_WADDR;
                end
                S_WADDR: begin
                    mem_req     = 1'b1;
                    mem_we      = 1'b1;
                    mem_addr    = cur_addr;
                    mem_wdata   = q.desc_word | DATA_W'(1 << DONE_BIT);
                    ptr_advance = 1'b1;
                    ptr_wrap    = q.desc_word[WRAP_BIT];
                    cause_set[CAUSE_RCOM] = 1'b1;
                    d.state     = S_FETCH;
                end
                S_STALL: begin
                    d.state = S_STALL;
                end
                default: d.state = S_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_OFF;
        end else begin
            q <= d;
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |-> !mem_req);  // R10
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_STALL && rx_enable) |=> (q.state == S_STALL && !mem_req));  // R7
    AST_DONE_ON_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == cur_addr) |-> mem_wdata[DONE_BIT]);  // R4
    AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);  // R2

endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_last,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_mcast,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              stat_rd,
    output logic [2:0]        irq_status,
    output logic              irq
);
    import rxr_pkg::*;

    logic [ADDR_W-1:0]  cur_addr;
    logic               ptr_load;
    logic               ptr_advance;
    logic               ptr_wrap;
    logic [CAUSE_W-1:0] cause_set;

    rxr_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .base_in (ring_base),
        .advance (ptr_advance),
        .wrap    (ptr_wrap),
        .cur     (cur_addr)
    );

    rxr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_enable   (rx_enable),
        .frm_valid   (frm_valid),
        .frm_data    (frm_data),
        .frm_last    (frm_last),
        .frm_len     (frm_len),
        .frm_mcast   (frm_mcast),
        .cur_addr    (cur_addr),
        .ptr_load    (ptr_load),
        .ptr_advance (ptr_advance),
        .ptr_wrap    (ptr_wrap),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .cause_set   (cause_set)
    );

    rxr_cause_reg #(.W(CAUSE_W)) u_cause (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (cause_set),
        .rd     (stat_rd),
        .status (irq_status),
        .irq    (irq)
    );

endmodule

// File: tb/sim_rx_desc_ring_writer.sv
module sim_rx_desc_ring_writer;

    localparam int NDESC = 4;
    localparam logic [31:0] RBASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic [31:0] ring_base = 32'h103;
    logic        frm_valid = 1'b0;
    logic [31:0] frm_data = '0;
    logic        frm_last = 1'b0;
    logic [10:0] frm_len = '0;
    logic        frm_mcast = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        stat_rd = 1'b0;
    logic [2:0]  irq_status;
    logic        irq;

    always #5 clk = ~clk;

    rx_desc_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_last(frm_last),
        .frm_len(frm_len), .frm_mcast(frm_mcast),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .stat_rd(stat_rd), .irq_status(irq_status), .irq(irq)
    );

    logic [31:0] mem [0:1023];
    logic [31:0] rdata_r = '0;
    assign mem_rdata = rdata_r;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        rdata_r <= mem[mem_addr[11:2]];
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] fdata [0:15];
    int exp_idx;

    function automatic logic [31:0] buf_of(int i);
        return 32'h400 + 32'(i) * 32'h100;
    endfunction

    function automatic logic [31:0] desc_of(int i);
        return RBASE + 32'(i) * 8;
    endfunction

    function automatic logic [31:0] addr_word(int i, bit done);
        return buf_of(i) | ((i == NDESC - 1) ? 32'h2 : 32'h0) | 32'(done);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic init_ring();
        for (int a = 0; a < 1024; a++) mem[a] = 32'hDEAD0000 | 32'(a);
        for (int i = 0; i < NDESC; i++) begin
            mem[desc_of(i) >> 2]       = addr_word(i, 1'b0);
            mem[(desc_of(i) + 4) >> 2] = 32'h0;
        end
    endtask

    task automatic release_desc(int i);
        mem[desc_of(i) >> 2] = addr_word(i, 1'b0);
    endtask

    task automatic make_frame(int n);
        for (int i = 0; i < n; i++) fdata[i] = $urandom;
    endtask

    task automatic send_frame(int n, logic [10:0] len, logic mc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frm_valid = 1'b1;
            frm_data  = fdata[i];
            frm_last  = (i == n - 1);
            frm_len   = (i == n - 1) ? len : 11'h0;
            frm_mcast = (i == n - 1) ? mc : 1'b0;
        end
    endtask

    task automatic idle(int c);
        for (int i = 0; i < c; i++) begin
            @(negedge clk);
            frm_valid = 1'b0;
            frm_last  = 1'b0;
        end
    endtask

    task automatic read_stat(output logic [2:0] v, input string req);
        @(negedge clk);
        v = irq_status;
        chk({req, " irq"}, 32'(irq), 32'(|v));
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic check_frame(int i, int n, logic [10:0] len, logic mc, string tag);
        chk({tag, " R4 addr word done"}, mem[desc_of(i) >> 2], addr_word(i, 1'b1));
        chk({tag, " R3 status word"}, mem[(desc_of(i) + 4) >> 2], {mc, 20'h0, len});
        for (int k = 0; k < n; k++)
            chk({tag, " R2 data"}, mem[(buf_of(i) >> 2) + k], fdata[k]);
    endtask

    initial begin
        logic [2:0]  st;
        logic [31:0] saved;
        int n;
        logic [10:0] len;
        logic mc;
        void'($urandom(32'd2024));
        init_ring();
        repeat (3) @(negedge clk);
        chk("R1 reset status", 32'(irq_status), 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);
        chk("R1 reset no access", 32'(mem_req), 32'h0);
        rst_n = 1'b1;

        // R10: frame while disabled is ignored
        make_frame(3);
        send_frame(3, 11'd12, 1'b0);
        idle(8);
        chk("R10 no cause", 32'(irq_status), 32'h0);
        chk("R10 desc untouched", mem[desc_of(0) >> 2], addr_word(0, 1'b0));

        // R1: enable with unaligned base
        @(negedge clk) rx_enable = 1'b1;
        idle(4);
        exp_idx = 0;

        // Random frames through the ring, including a wrap (R5)
        for (int f = 0; f < 6; f++) begin
            n   = 1 + int'($urandom % 16);
            len = 11'(n * 4 - int'($urandom % 4));
            mc  = 1'($urandom);
            make_frame(n);
            send_frame(n, len, mc);
            idle(8);
            check_frame(exp_idx, n, len, mc, (f >= NDESC) ? "R5 wrap" : "R1 ring");
            read_stat(st, "R6");
            chk("R6 rcom cause", 32'(st), 32'h1);
            release_desc(exp_idx);
            exp_idx = (exp_idx + 1) % NDESC;
        end
        read_stat(st, "R9");
        chk("R9 cleared by read", 32'(st), 32'h0);

        // R7: fill the ring without releasing
        for (int f = 0; f < NDESC; f++) begin
            n = 2 + f;
            len = 11'(n * 4);
            make_frame(n);
            send_frame(n, len, 1'b1);
            idle(8);
            check_frame(exp_idx, n, len, 1'b1, "R7 fill");
            read_stat(st, "R7");
            chk("R7 cause after fill", 32'(st), (f == NDESC - 1) ? 32'h3 : 32'h1);
            exp_idx = (exp_idx + 1) % NDESC;
        end
        saved = mem[(desc_of(exp_idx) + 4) >> 2];
        make_frame(5);
        send_frame(5, 11'd20, 1'b0);
        idle(8);
        read_stat(st, "R8");
        chk("R8 overrun while stalled", 32'(st), 32'h4);
        chk("R8 stalled frame not stored", mem[(desc_of(exp_idx) + 4) >> 2], saved);

        for (int i = 0; i < NDESC; i++) release_desc(i);
        idle(10);
        send_frame(5, 11'd20, 1'b0);
        idle(8);
        read_stat(st, "R7");
        chk("R7 release alone no restart", 32'(st), 32'h4);

        // R7: enable toggle restarts at first descriptor
        @(negedge clk) rx_enable = 1'b0;
        idle(2);
        @(negedge clk) rx_enable = 1'b1;
        idle(4);
        make_frame(7);
        send_frame(7, 11'd27, 1'b1);
        idle(8);
        check_frame(0, 7, 11'd27, 1'b1, "R7 restart idx0");
        read_stat(st, "R7");
        chk("R7 restart rcom", 32'(st), 32'h1);
        exp_idx = 1;

        // R8: frame starting during writeback is dropped
        make_frame(4);
        send_frame(4, 11'd15, 1'b0);
        send_frame(6, 11'd24, 1'b1);
        idle(8);
        check_frame(1, 4, 11'd15, 1'b0, "R8 first kept");
        read_stat(st, "R8");
        chk("R8 rcom and overrun", 32'(st), 32'h5);
        chk("R8 next desc still free", mem[desc_of(2) >> 2], addr_word(2, 1'b0));
        make_frame(3);
        send_frame(3, 11'd9, 1'b1);
        idle(8);
        check_frame(2, 3, 11'd9, 1'b1, "R8 next frame");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule